// File: doc/BRIEF.md
# Parallel Port Strobe Sequencer

This block is a byte-wide parallel master port for simple slave devices such as latches, FIFOs or memories. A requester asks for one of three transfers: an address write, a data write or a data read. The block then runs a fixed timing sequence on its control outputs. These outputs are a chip select, an output enable for reads, a drive enable for the data bus, and two clock strobes. When the sequence ends, the block returns read data together with a one-cycle done pulse.

An 8-bit configuration byte controls the sequence. It picks one of three ways to steer transfers onto the two strobes, enables or silences the chip select, enables or silences the first strobe, and sets a count of extra wait states. The wait states are added in pairs, one half after each of the two base cycles. Timing advances only on clock cycles where the cycle-enable input is high, so the data-source rate sets the pace. The block keeps bit 0 of the most recent address write and uses it to steer data transfers in odd/even mode.

Top module: `par_strobe_seq`

## Requirements
- R1: After reset the configuration byte is zero, and busy, done, both strobes, chip_sel, out_en and pdata_oe are all low.
- R2: A request (req_valid high) is accepted only while busy is low. A request made while busy is ignored. busy rises on the cycle after acceptance and stays high through the single cycle in which done is high. busy is low on the cycle after done.
- R3: The configuration byte holds the wait code W in bits 3:0. With cyc_en held high and acceptance at edge 0, the strobe phase occupies cycle W+2 and done is high in cycle 2W+3. Counted in enabled cycles, one transaction spans 2W+2 ticks before done: a setup tick, W wait ticks, the strobe tick and W more wait ticks.
- R4: A cycle with cyc_en low leaves the sequence where it is. Only enabled cycles count toward the 2W+2 ticks.
- R5: When cfg bits 7:6 are 00, an address write (req_op 00) goes to strobe1. Data writes (req_op 01) and data reads (req_op 1x) go to strobe2.
- R6: When cfg bits 7:6 are 01, writes of either kind go to strobe1 and reads go to strobe2.
- R7: When cfg bit 7 is 1, a transfer goes to strobe1 if the stored address bit is 1 and to strobe2 if it is 0. The stored bit is bit 0 of the latest address write, and an address write uses its own bit 0. At most one strobe is high in any cycle.
- R8: When cfg bit 5 is 1, chip_sel is high for every cycle of the transaction before the done cycle. When bit 5 is 0, chip_sel stays low.
- R9: When cfg bit 4 is 0, strobe1 stays low even for transfers routed to it. strobe2 is not affected by this bit.
- R10: For reads, out_en is high and pdata_oe is low during the transaction. rd_data takes the value on pdata_in at the last enabled cycle of the strobe phase. For writes, pdata_oe is high with pdata_out equal to the request data, and out_en stays low.
- R11: A transaction uses the configuration in force when it was accepted. A configuration write in the same cycle as acceptance, or during the transaction, takes effect from the next transaction on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Data-source cycle enable; the sequence advances only when high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [7:6] routing, [5] chip-select enable, [4] strobe1 enable, [3:0] wait code |
| req_valid | input | 1 | Transfer request |
| req_op | input | 2 | 00 address write, 01 data write, 1x data read |
| req_data | input | 8 | Address or data byte to send |
| busy | output | 1 | High from acceptance through done |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last captured read byte |
| pdata_out | output | 8 | Parallel bus output value |
| pdata_oe | output | 1 | Bus drive enable during writes |
| pdata_in | input | 8 | Parallel bus input value |
| out_en | output | 1 | Slave output enable during reads |
| chip_sel | output | 1 | Slave chip select |
| strobe1 | output | 1 | First clock strobe |
| strobe2 | output | 1 | Second clock strobe |

## Verification
Two functions can land on the same clock edge: a configuration write and the acceptance of a request. The bench drives cfg_we and req_valid together on one edge, using a new byte whose routing, enables and wait code all differ from the old one. It then checks that strobe steering, chip select and tick count follow the old byte, and that the next transaction follows the new one. A second request raised while busy is checked to have no effect: the sequence keeps its timing, and busy falls on the cycle after done.

// File: rtl/par_strobe_pkg.sv
package par_strobe_pkg;

    parameter int DATA_W = 8;
    parameter int WS_W   = 4;

    localparam logic [1:0] OP_ADDR_WR = 2'b00;
    localparam logic [1:0] OP_DATA_WR = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WAIT_A,
        PH_STROBE,
        PH_WAIT_B,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic [1:0]      route;
        logic            cs_en;
        logic            s1_en;
        logic [WS_W-1:0] ws;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // 1 when the transfer belongs to the first strobe
    function automatic logic to_first(input logic [1:0] mode,
                                      input logic [1:0] op,
                                      input logic       odd);
        logic f;
        if (mode[1])      f = odd;
        else if (mode[0]) f = ~op[1];
        else              f = (op == OP_ADDR_WR);
        return f;
    endfunction

endpackage

// File: rtl/par_cfg_reg.sv
module par_cfg_reg
    import par_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= cfg_t'(wdata);
    end
endmodule

// File: rtl/par_seq_fsm.sv
module par_seq_fsm
    import par_strobe_pkg::*;
#(
    parameter int CW = WS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_en,
    input  logic          start,
    input  logic [CW-1:0] ws,
    output phase_e        phase,
    output logic          cap
);
    logic [CW-1:0] cnt;

    assign cap = (phase == PH_STROBE) && cyc_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE:   if (start) phase <= PH_SETUP;
                PH_SETUP:  if (cyc_en) begin
                               if (ws == '0) phase <= PH_STROBE;
                               else begin
                                   cnt   <= ws;
                                   phase <= PH_WAIT_A;
                               end
                           end
                PH_WAIT_A: if (cyc_en) begin
                               if (cnt == CW'(1)) phase <= PH_STROBE;
                               else               cnt   <= cnt - 1'b1;
                           end
                PH_STROBE: if (cyc_en) begin
                               if (ws == '0) phase <= PH_FIN;
                               else begin
                                   cnt   <= ws;
                                   phase <= PH_WAIT_B;
                               end
                           end
                PH_WAIT_B: if (cyc_en) begin
                               if (cnt == CW'(1)) phase <= PH_FIN;
                               else               cnt   <= cnt - 1'b1;
                           end
                PH_FIN:    phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/par_strobe_route.sv
module par_strobe_route
    import par_strobe_pkg::*;
(
    input  cfg_t       cfg,
    input  logic [1:0] op,
    input  logic       odd,
    input  phase_e     phase,
    output logic       strobe1,
    output logic       strobe2,
    output logic       chip_sel,
    output logic       out_en,
    output logic       drive_en
);
    logic active, str_ph, first;

    always_comb begin
        active   = (phase == PH_SETUP) || (phase == PH_WAIT_A) ||
                   (phase == PH_STROBE) || (phase == PH_WAIT_B);
        str_ph   = (phase == PH_STROBE);
        first    = to_first(cfg.route, op, odd);
        strobe1  = str_ph & first & cfg.s1_en;
        strobe2  = str_ph & ~first;
        chip_sel = active & cfg.cs_en;
        out_en   = active & op[1];
        drive_en = active & ~op[1];
    end
endmodule

// File: rtl/par_strobe_seq.sv
module par_strobe_seq
    import par_strobe_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [DW-1:0]    req_data,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    pdata_out,
    output logic             pdata_oe,
    input  logic [DW-1:0]    pdata_in,
    output logic             out_en,
    output logic             chip_sel,
    output logic             strobe1,
    output logic             strobe2
);
    cfg_t          cfg_live, cfg_txn;
    phase_e        phase;
    logic          cap, accept, odd_q;
    logic [1:0]    op_q;
    logic [DW-1:0] data_q, rd_q;

    assign accept = req_valid && (phase == PH_IDLE);

    par_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_live)
    );

    par_seq_fsm #(.CW(WS_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cyc_en (cyc_en),
        .start  (accept),
        .ws     (cfg_txn.ws),
        .phase  (phase),
        .cap    (cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_txn <= '0;
            op_q    <= '0;
            data_q  <= '0;
            odd_q   <= 1'b0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                cfg_txn <= cfg_live;
                op_q    <= req_op;
                data_q  <= req_data;
                if (req_op == OP_ADDR_WR) odd_q <= req_data[0];
            end
            if (cap && op_q[1]) rd_q <= pdata_in;
        end
    end

    par_strobe_route u_route (
        .cfg      (cfg_txn),
        .op       (op_q),
        .odd      (odd_q),
        .phase    (phase),
        .strobe1  (strobe1),
        .strobe2  (strobe2),
        .chip_sel (chip_sel),
        .out_en   (out_en),
        .drive_en (pdata_oe)
    );

    assign busy      = (phase != PH_IDLE);
    assign done      = (phase == PH_FIN);
    assign rd_data   = rd_q;
    assign pdata_out = data_q;
endmodule

// File: rtl/par_strobe_seq_chk.sv
module par_strobe_seq_chk (
    input logic clk,
    input logic rst,
    input logic cyc_en,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic strobe1,
    input logic strobe2,
    input logic chip_sel,
    input logic out_en,
    input logic pdata_oe
);
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);                                              // R2
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));                                  // R2
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);                              // R2
    AST_STROBE_SINGLE_TICK: assert property (@(posedge clk) disable iff (rst)
        ((strobe1 || strobe2) && cyc_en) |=> !(strobe1 || strobe2)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !cyc_en) |=>
            ($stable(strobe1) && $stable(strobe2) && $stable(chip_sel))); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobe1, strobe2}));                               // R7
    AST_CS_IN_TXN: assert property (@(posedge clk) disable iff (rst)
        chip_sel |-> (busy && !done));                               // R8
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !(out_en && pdata_oe));                                      // R10
endmodule

bind par_strobe_seq par_strobe_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_en    (cyc_en),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .strobe1   (strobe1),
    .strobe2   (strobe2),
    .chip_sel  (chip_sel),
    .out_en    (out_en),
    .pdata_oe  (pdata_oe)
);

// File: tb/par_strobe_seq_test.sv
module par_strobe_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [7:0] req_data = '0;
    logic [7:0] pdata_in = '0;
    logic       busy, done, pdata_oe, out_en, chip_sel, strobe1, strobe2;
    logic [7:0] rd_data, pdata_out;

    int   n_run = 0, n_fail = 0;
    logic [7:0] cfg_m = '0;
    bit   odd_m = 1'b0;
    bit   stall_mode = 1'b0;
    int   last_err = 0;

    always #4 clk = ~clk;

    par_strobe_seq uut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .busy(busy), .done(done), .rd_data(rd_data),
        .pdata_out(pdata_out), .pdata_oe(pdata_oe), .pdata_in(pdata_in),
        .out_en(out_en), .chip_sel(chip_sel), .strobe1(strobe1),
        .strobe2(strobe2)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected {strobe2, strobe1} for a transfer under a configuration byte
    function automatic logic [1:0] exp_pair(input logic [7:0] c, input logic [1:0] op, input bit odd);
        bit first;
        if (c[7])      first = odd;
        else if (c[6]) first = (op != 2'b10) && (op != 2'b11);
        else           first = (op == 2'b00);
        return {~first, first & c[4]};
    endfunction

    function automatic string route_tag(input logic [7:0] c);
        if (c[7]) return "R7";
        if (c[6]) return "R6";
        return "R5";
    endfunction

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = v;
    endtask

    task automatic txn(input logic [1:0] op, input logic [7:0] d,
                       input bit with_cfg, input logic [7:0] newc, input bit poke);
        logic [7:0] c   = cfg_m;
        int         w   = int'(c[3:0]);
        bit         odd = (op == 2'b00) ? d[0] : odd_m;
        bit         rd  = op[1];
        logic [1:0] ep  = exp_pair(c, op, odd);
        logic [7:0] pin = 8'($urandom);
        int k = 1, ticks = 0, e_s = 0, e_cs = 0, e_bus = 0, done_k = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d;
        if (with_cfg) begin cfg_we = 1'b1; cfg_wdata = newc; end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        while (k < 200) begin
            bit sph = (ticks == w + 1);
            if (k == 1 && poke) begin req_valid = 1'b1; req_op = ~op; req_data = ~d; end
            if (k == 2) req_valid = 1'b0;
            if (done) begin done_k = k; break; end
            if (strobe1 !== (sph & ep[0]) || strobe2 !== (sph & ep[1])) e_s++;
            if (chip_sel !== c[5]) e_cs++;
            if (out_en !== rd || pdata_oe !== !rd) e_bus++;
            if (!rd && pdata_out !== d) e_bus++;
            cyc_en   = stall_mode ? 1'($urandom) : 1'b1;
            pdata_in = sph ? pin : ~pin;
            if (cyc_en) ticks++;
            @(negedge clk);
            k++;
        end
        cyc_en = 1'b1;
        last_err = e_s + e_cs;
        chk(done_k != 0 && ticks == 2 * w + 2, "R3 tick count", ticks, 2 * w + 2);
        if (!stall_mode)
            chk(done_k == 2 * w + 3, "R3 done cycle", done_k, 2 * w + 3);
        else
            chk(e_s == 0, "R4 stalled strobe timing", e_s, 0);
        chk(e_s == 0, route_tag(c), e_s, 0);
        if (c[4] == 1'b0) chk(e_s == 0, "R9 strobe1 disabled", e_s, 0);
        chk(e_cs == 0, "R8 chip select", e_cs, 0);
        chk(e_bus == 0, "R10 bus controls", e_bus, 0);
        if (rd) chk(rd_data === pin, "R10 read capture", int'(rd_data), int'(pin));
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R2 release after done", int'(busy), 0);
        if (op == 2'b00) odd_m = d[0];
        if (with_cfg) cfg_m = newc;
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !strobe1 && !strobe2 && !chip_sel && !out_en && !pdata_oe,
            "R1 reset outputs", int'({busy, done, strobe1, strobe2, chip_sel, out_en, pdata_oe}), 0);
        txn(2'b01, 8'h3C, 1'b0, 8'h00, 1'b0);          // R1 zero configuration
        cfg_write(8'b00_1_1_0000);                       // R5
        txn(2'b00, 8'h11, 1'b0, 8'h00, 1'b0);
        txn(2'b01, 8'hA5, 1'b0, 8'h00, 1'b0);
        txn(2'b10, 8'h00, 1'b0, 8'h00, 1'b0);
        cfg_write(8'b01_1_1_0011);                       // R6
        txn(2'b01, 8'h5A, 1'b0, 8'h00, 1'b0);
        txn(2'b11, 8'h00, 1'b0, 8'h00, 1'b0);
        txn(2'b00, 8'h20, 1'b0, 8'h00, 1'b1);            // R2 poke while busy
        cfg_write(8'b10_1_1_1111);                       // R7 largest wait code
        txn(2'b00, 8'h07, 1'b0, 8'h00, 1'b0);
        txn(2'b01, 8'h99, 1'b0, 8'h00, 1'b0);
        txn(2'b00, 8'h06, 1'b0, 8'h00, 1'b0);
        txn(2'b10, 8'h00, 1'b0, 8'h00, 1'b0);
        cfg_write(8'b00_0_0_0001);                       // R8 R9 disabled
        txn(2'b00, 8'h01, 1'b0, 8'h00, 1'b0);
        txn(2'b10, 8'h01, 1'b0, 8'h00, 1'b0);
        cfg_write(8'b00_1_1_0010);                       // R11 config with accept
        txn(2'b00, 8'h44, 1'b1, 8'b11_0_0_0111, 1'b0);
        chk(last_err == 0, "R11 old config used", last_err, 0);
        txn(2'b00, 8'h45, 1'b0, 8'h00, 1'b0);
        chk(last_err == 0, "R11 new config used", last_err, 0);
        stall_mode = 1'b1;                               // R4
        cfg_write(8'b01_1_1_0010);
        txn(2'b10, 8'h00, 1'b0, 8'h00, 1'b0);
        txn(2'b01, 8'hC3, 1'b0, 8'h00, 1'b0);
        for (int i = 0; i < 40; i++) begin
            stall_mode = 1'($urandom);
            if ($urandom % 3 == 0) cfg_write(8'($urandom));
            txn(2'($urandom), 8'($urandom), 1'($urandom % 4 == 0), 8'($urandom), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule